// File: doc/BRIEF.md
# Nibble-Operand Stack Processor Core

This block is a small 32-bit processor core. It runs a stream of one-byte instructions and holds its working values in a three-deep evaluation stack rather than a register file. The top nibble of each byte selects one of sixteen function codes. The bottom nibble carries four bits of operand. Two prefix codes let a program build an operand of any width, a nibble at a time, in an operand register. A workspace pointer gives each program a frame of word-sized local slots. An instruction pointer tracks the next byte to run.

Instruction bytes come in through a byte-wide fetch port. An independent prefetch state machine keeps a small queue of bytes ahead of the core and discards that queue whenever a jump is taken.

Execution is sequenced by a three-state controller:
- DECODE takes one byte from the queue and assembles the operand.
  - On a prefix byte, DECODE stays in DECODE.
  - On any other byte, it moves to EXEC.
- EXEC performs the operation, or issues a data memory access.
  - After a read, EXEC moves to LOAD.
  - Otherwise, EXEC returns to DECODE.
- LOAD captures the read data and returns to DECODE.

The prefetch machine has three states:
- FBOOT is held for the first cycle after reset and then moves to FRUN.
- In FRUN, the machine requests the next byte.
- In FHOLD, requests stop because the queue and the requests in flight fill it. The machine returns to FRUN once there is room.

Top module: `nsc_core`

## Requirements
- R1: Each instruction is one byte: bits 7:4 are the function code and bits 3:0 the operand nibble. The codes are: 0 jump, 1 local pointer, 2 prefix, 3 non-local load, 4 load constant, 5 non-local pointer, 6 negative prefix, 7 local load, 8 add constant, 9 reserved, 10 conditional jump, 11 adjust workspace, 12 equals constant, 13 local store, 14 non-local store, 15 operate.
- R2: Every byte first ORs its nibble into the operand register to form the operand O. Code 2 then leaves O shifted left by 4 in the register. Code 6 leaves the bitwise inverse of O, shifted left by 4. Every other code clears the register to zero after use.
- R3: Load constant pushes O. Add constant sets A to A+O. Equals constant sets A to 1 when A equals O, and to 0 otherwise.
- R4: A push moves C←B and B←A, then writes A. A pop moves A←B and B←C and leaves C unchanged.
- R5: Local load pushes the word at W+4·O. Local store writes A to W+4·O and pops.
- R6: Local pointer pushes W+4·O. Non-local pointer sets A to A+4·O. Non-local load replaces A with the word at A+4·O. Non-local store writes B to A+4·O and sets A←C.
- R7: Jump sets the instruction pointer to the address of the following byte plus O, with O taken as a signed value.
- R8: Conditional jump branches like a jump when A is zero and leaves the stack unchanged. When A is non-zero it pops the stack and falls through.
- R9: Operate with O=0 swaps A and B. O=5 pops and sets A to B+A. O=12 pops and sets A to B−A. Any other O, and code 9, leave the stack unchanged.
- R10: Adjust workspace sets W to W+4·O.
- R11: Reset clears A, B, C and the operand register, sets the instruction pointer to RESET_IP and W to RESET_WS, and issues no data access.
- R12: After reset, byte fetches start at RESET_IP and run through consecutive addresses. The next request after a taken jump is for the target address.
- R13: A data read returns its word one cycle after the request. A read and a write are never issued together, and neither is issued outside EXEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| fetch_req | output | 1 | Instruction byte request |
| fetch_addr | output | DW | Byte address of the request |
| fetch_data | input | 8 | Byte returned one cycle after the request |
| dmem_rd | output | 1 | Data word read request |
| dmem_wr | output | 1 | Data word write request |
| dmem_addr | output | DW | Byte address of the data word |
| dmem_wdata | output | DW | Write data |
| dmem_rdata | input | DW | Read data, valid one cycle after dmem_rd |
| stack_top | output | DW | Current value of register A |

## Verification
- **Cycle cost:** a fetched byte lands in the queue one cycle after its request. Each byte then spends one cycle in DECODE. A non-prefix byte adds one EXEC cycle, and a load adds one LOAD cycle. A taken jump costs two extra cycles before the target byte is queued.
- **Sampling:** every program ends in a two-byte self-loop that leaves the stack untouched. The bench runs each program for a fixed 150 cycles, far above its longest path, and then samples A and the data memory on a falling edge.
- **Fetch order:** the order of fetch addresses is logged on falling edges from the first request after reset.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    typedef enum logic [3:0] {
        FN_J     = 4'd0,
        FN_LDLP  = 4'd1,
        FN_PFIX  = 4'd2,
        FN_LDNL  = 4'd3,
        FN_LDC   = 4'd4,
        FN_LDNLP = 4'd5,
        FN_NFIX  = 4'd6,
        FN_LDL   = 4'd7,
        FN_ADC   = 4'd8,
        FN_RSVD  = 4'd9,
        FN_CJ    = 4'd10,
        FN_AJW   = 4'd11,
        FN_EQC   = 4'd12,
        FN_STL   = 4'd13,
        FN_STNL  = 4'd14,
        FN_OPR   = 4'd15
    } fn_e;

    localparam int OPR_REV = 0;
    localparam int OPR_ADD = 5;
    localparam int OPR_SUB = 12;

    typedef enum logic [1:0] {
        ST_DECODE = 2'd0,
        ST_EXEC   = 2'd1,
        ST_LOAD   = 2'd2
    } core_st_e;

    typedef enum logic [1:0] {
        PF_BOOT = 2'd0,
        PF_RUN  = 2'd1,
        PF_HOLD = 2'd2
    } pf_st_e;

endpackage

// File: rtl/nsc_prefetch.sv
module nsc_prefetch
    import nsc_pkg::*;
#(
    parameter int               AW    = 32,
    parameter int               DEPTH = 4,
    parameter logic [AW-1:0]    START = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          pop,
    output logic          byte_valid,
    output logic [7:0]    byte_out,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic [7:0]    fetch_data
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    pf_st_e         st, st_n;
    logic [7:0]     q_mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CW-1:0]  cnt, cnt_n;
    logic           pend;
    logic [AW-1:0]  fa;
    logic           push, popq;
    logic [CW:0]    occ_n;

    assign push  = pend && !flush;
    assign popq  = pop && !flush && (cnt != '0);
    assign cnt_n = flush ? '0 : (cnt + CW'(push) - CW'(popq));
    assign occ_n = {1'b0, cnt_n} + (CW+1)'(fetch_req);

    // output process
    always_comb begin
        fetch_req = 1'b0;
        unique case (st)
            PF_BOOT: fetch_req = 1'b0;
            PF_RUN:  fetch_req = !flush;
            PF_HOLD: fetch_req = 1'b0;
            default: fetch_req = 1'b0;
        endcase
        st_n = (occ_n >= (CW+1)'(DEPTH)) ? PF_HOLD : PF_RUN;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PF_BOOT;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            pend <= 1'b0;
            fa   <= START;
        end else begin
            cnt  <= cnt_n;
            pend <= fetch_req;
            if (flush) begin
                wp <= '0;
                rp <= '0;
                fa <= flush_addr;
            end else begin
                if (push)      wp <= wp + PW'(1);
                if (popq)      rp <= rp + PW'(1);
                if (fetch_req) fa <= fa + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) q_mem[wp] <= fetch_data;
    end

    assign byte_valid = (cnt != '0);
    assign byte_out   = q_mem[rp];
    assign fetch_addr = fa;

endmodule

// File: rtl/nsc_opnd.sv
module nsc_opnd
    import nsc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] oreg,
    input  logic [7:0]    ibyte,
    output fn_e           fn,
    output logic [DW-1:0] opval,
    output logic          is_pfx,
    output logic [DW-1:0] oreg_pfx
);

    always_comb begin
        fn       = fn_e'(ibyte[7:4]);
        opval    = oreg | DW'(ibyte[3:0]);
        is_pfx   = (fn == FN_PFIX) || (fn == FN_NFIX);
        oreg_pfx = ((fn == FN_NFIX) ? ~opval : opval) << 4;
    end

endmodule

// File: rtl/nsc_alu.sv
module nsc_alu
    import nsc_pkg::*;
#(
    parameter int DW = 32
) (
    input  fn_e           fn,
    input  logic [DW-1:0] opv,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] wptr,
    input  logic [DW-1:0] iptr,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] result,
    output logic [DW-1:0] jtarget
);

    logic [DW-1:0] scaled, base;

    always_comb begin
        scaled  = opv << 2;
        base    = (fn == FN_LDNL || fn == FN_STNL || fn == FN_LDNLP) ? a : wptr;
        ea      = base + scaled;
        jtarget = iptr + opv;
        unique case (fn)
            FN_LDLP, FN_LDNLP: result = ea;
            FN_LDC:            result = opv;
            FN_ADC:            result = a + opv;
            FN_EQC:            result = {{(DW-1){1'b0}}, (a == opv)};
            FN_OPR: begin
                if (opv == DW'(OPR_ADD))      result = b + a;
                else if (opv == DW'(OPR_SUB)) result = b - a;
                else                          result = b;
            end
            default:           result = a;
        endcase
    end

endmodule

// File: rtl/nsc_core.sv
module nsc_core
    import nsc_pkg::*;
#(
    parameter int            DW       = 32,
    parameter int            QDEPTH   = 4,
    parameter logic [DW-1:0] RESET_IP = '0,
    parameter logic [DW-1:0] RESET_WS = DW'(256)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          fetch_req,
    output logic [DW-1:0] fetch_addr,
    input  logic [7:0]    fetch_data,
    output logic          dmem_rd,
    output logic          dmem_wr,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata,
    output logic [DW-1:0] stack_top
);

    core_st_e       state, state_n;
    logic [DW-1:0]  a, b, c, oreg, wptr, iptr, opv_q;
    fn_e            fn_q;

    logic           byte_valid, pf_pop, pf_flush;
    logic [7:0]     byte_cur;
    fn_e            dec_fn;
    logic [DW-1:0]  dec_opv, oreg_pfx;
    logic           dec_pfx;
    logic [DW-1:0]  ea, alu_res, jtarget;

    nsc_prefetch #(.AW(DW), .DEPTH(QDEPTH), .START(RESET_IP)) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (pf_flush),
        .flush_addr (jtarget),
        .pop        (pf_pop),
        .byte_valid (byte_valid),
        .byte_out   (byte_cur),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data)
    );

    nsc_opnd #(.DW(DW)) u_opnd (
        .oreg     (oreg),
        .ibyte    (byte_cur),
        .fn       (dec_fn),
        .opval    (dec_opv),
        .is_pfx   (dec_pfx),
        .oreg_pfx (oreg_pfx)
    );

    nsc_alu #(.DW(DW)) u_alu (
        .fn      (fn_q),
        .opv     (opv_q),
        .a       (a),
        .b       (b),
        .wptr    (wptr),
        .iptr    (iptr),
        .ea      (ea),
        .result  (alu_res),
        .jtarget (jtarget)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DECODE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n  = state;
        pf_pop   = 1'b0;
        pf_flush = 1'b0;
        dmem_rd  = 1'b0;
        dmem_wr  = 1'b0;
        unique case (state)
            ST_DECODE: begin
                if (byte_valid) begin
                    pf_pop = 1'b1;
                    if (!dec_pfx) state_n = ST_EXEC;
                end
            end
            ST_EXEC: begin
                state_n = ST_DECODE;
                unique case (fn_q)
                    FN_J:           pf_flush = 1'b1;
                    FN_CJ:          pf_flush = (a == '0);
                    FN_LDL, FN_LDNL: begin
                        dmem_rd = 1'b1;
                        state_n = ST_LOAD;
                    end
                    FN_STL, FN_STNL: dmem_wr = 1'b1;
                    default: ;
                endcase
            end
            ST_LOAD: state_n = ST_DECODE;
            default: state_n = ST_DECODE;
        endcase
    end

    assign dmem_addr  = ea;
    assign dmem_wdata = (fn_q == FN_STL) ? a : b;
    assign stack_top  = a;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a     <= '0;
            b     <= '0;
            c     <= '0;
            oreg  <= '0;
            opv_q <= '0;
            fn_q  <= FN_RSVD;
            iptr  <= RESET_IP;
            wptr  <= RESET_WS;
        end else begin
            unique case (state)
                ST_DECODE: begin
                    if (byte_valid) begin
                        iptr <= iptr + DW'(1);
                        if (dec_pfx) begin
                            oreg <= oreg_pfx;
                        end else begin
                            oreg  <= '0;
                            fn_q  <= dec_fn;
                            opv_q <= dec_opv;
                        end
                    end
                end
                ST_EXEC: begin
                    unique case (fn_q)
                        FN_J: iptr <= jtarget;
                        FN_LDLP, FN_LDC: begin
                            c <= b;
                            b <= a;
                            a <= alu_res;
                        end
                        FN_LDNLP, FN_ADC, FN_EQC: a <= alu_res;
                        FN_CJ: begin
                            if (a == '0) begin
                                iptr <= jtarget;
                            end else begin
                                a <= b;
                                b <= c;
                            end
                        end
                        FN_AJW: wptr <= ea;
                        FN_STL: begin
                            a <= b;
                            b <= c;
                        end
                        FN_STNL: a <= c;
                        FN_OPR: begin
                            if (opv_q == DW'(OPR_REV)) begin
                                a <= b;
                                b <= a;
                            end else if (opv_q == DW'(OPR_ADD) || opv_q == DW'(OPR_SUB)) begin
                                a <= alu_res;
                                b <= c;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_LOAD: begin
                    if (fn_q == FN_LDL) begin
                        c <= b;
                        b <= a;
                    end
                    a <= dmem_rdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nsc_core_chk.sv
module nsc_core_chk
    import nsc_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic [DW-1:0] fetch_addr,
    input logic          flush,
    input logic [DW-1:0] flush_addr,
    input logic          dmem_rd,
    input logic          dmem_wr,
    input core_st_e      state,
    input logic [DW-1:0] oreg
);

    AST_FETCH_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && $past(fetch_req) && !$past(flush)) |-> fetch_addr == $past(fetch_addr) + DW'(1)); // R12

    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fetch_req && fetch_addr == $past(flush_addr))); // R7

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr)); // R13

    AST_READ_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> state == ST_LOAD); // R13

    AST_MEM_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |-> (!dmem_rd && !dmem_wr)); // R13

    AST_OPERAND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> oreg == '0); // R2

endmodule

bind nsc_core nsc_core_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .flush      (pf_flush),
    .flush_addr (jtarget),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .state      (state),
    .oreg       (oreg)
);

// File: tb/nsc_core_test.sv
module nsc_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 150;
    localparam int WATCHDOG   = 190000;
    localparam int WS         = 256;

    localparam int F_J = 0, F_LDLP = 1, F_PFIX = 2, F_LDNL = 3, F_LDC = 4, F_LDNLP = 5,
                   F_NFIX = 6, F_LDL = 7, F_ADC = 8, F_RSV = 9, F_CJ = 10, F_AJW = 11,
                   F_EQC = 12, F_STL = 13, F_STNL = 14, F_OPR = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic        dmem_rd, dmem_wr;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic [31:0] stack_top;

    logic [7:0]  imem [256];
    logic [31:0] dmem [256];
    logic [7:0]  prog [128];
    int          plen;
    int          tests = 0;
    int          fails = 0;
    int          flog [8];
    int          flog_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    nsc_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .stack_top  (stack_top)
    );

    always @(posedge clk) begin
        if (fetch_req) fetch_data <= imem[fetch_addr[7:0]];
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 32'd0;
        end else begin
            if (dmem_wr) dmem[dmem_addr[9:2]] <= dmem_wdata;
            if (dmem_rd) dmem_rdata <= dmem[dmem_addr[9:2]];
        end
    end

    always @(negedge clk) begin
        if (!rst_n) flog_n = 0;
        else if (fetch_req && flog_n < 8) begin
            flog[flog_n] = fetch_addr;
            flog_n++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    task automatic emit(input int fn, input int v);
        int fns [10];
        int nib [10];
        int n = 0;
        int cur = v;
        int f = fn;
        for (int guard = 0; guard < 10; guard++) begin
            fns[n] = f;
            nib[n] = cur & 15;
            n++;
            if (cur >= 0 && cur < 16) break;
            if (cur >= 16) begin
                f = F_PFIX;
                cur = cur >>> 4;
            end else begin
                f = F_NFIX;
                cur = (~cur) >>> 4;
            end
        end
        for (int k = n - 1; k >= 0; k--) begin
            prog[plen] = 8'((fns[k] << 4) | nib[k]);
            plen++;
        end
    endtask

    task automatic raw(input int bval);
        prog[plen] = 8'(bval);
        plen++;
    endtask

    task automatic start_prog();
        plen = 0;
    endtask

    task automatic run_prog();
        emit(F_J, -2);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) imem[i] = 8'h00;
        for (int i = 0; i < plen; i++) imem[i] = prog[i];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (RUN_CYCLES) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int vals [8];
        int ok;
        vals = '{0, 1, 7, -1, 100, -300, 32'h7FFFFFFF, 32'h00012345};

        // R11: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 A after reset", stack_top, 0);
        check("R11 no data access in reset", {30'd0, dmem_rd, dmem_wr}, 0);

        // R1 R2 R3: constant sweep through prefix encoding
        for (int k = 0; k < 32; k++) begin
            for (int s = 0; s < 2; s++) begin
                int v;
                v = (s == 0) ? (1 << k) : -(1 << k);
                start_prog();
                emit(F_LDC, v);
                run_prog();
                check("R2 prefixed constant", stack_top, v);
            end
        end
        foreach (vals[i]) begin
            start_prog();
            emit(F_LDC, vals[i] + 17);
            run_prog();
            check("R3 constant", stack_top, vals[i] + 17);
        end

        // R4 R9 R5: add and subtract sweep
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                start_prog();
                emit(F_LDC, vals[i]);
                emit(F_LDC, vals[j]);
                emit(F_OPR, 5);
                emit(F_STL, 0);
                emit(F_LDC, vals[i]);
                emit(F_LDC, vals[j]);
                emit(F_OPR, 12);
                run_prog();
                check("R9 subtract", stack_top, vals[i] - vals[j]);
                check("R9 add via R5 store", dmem[WS/4], vals[i] + vals[j]);
            end
        end

        // R4: three-deep stack
        start_prog();
        emit(F_LDC, 2); emit(F_LDC, 30); emit(F_LDC, 400);
        emit(F_OPR, 5); emit(F_OPR, 5);
        run_prog();
        check("R4 three-deep add", stack_top, 432);

        // R9: reverse then subtract
        start_prog();
        emit(F_LDC, 11); emit(F_LDC, 50); emit(F_OPR, 0); emit(F_OPR, 12);
        run_prog();
        check("R9 reverse", stack_top, 39);

        // R9 R2: reserved code and unknown operate are no-ops, operand cleared
        start_prog();
        emit(F_LDC, 5); raw(8'h93); raw(8'hF1); emit(F_ADC, 1);
        run_prog();
        check("R9 no-op codes", stack_top, 6);

        // R3: add constant and equals constant
        start_prog();
        emit(F_LDC, 1000); emit(F_ADC, -7);
        run_prog();
        check("R3 add negative constant", stack_top, 993);
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 2; j++) begin
                int av, kv;
                av = (i == 0) ? 0 : (i == 1) ? 3 : -1;
                kv = (j == 0) ? 0 : 3;
                start_prog();
                emit(F_LDC, av); emit(F_EQC, kv);
                run_prog();
                check("R3 equals constant", stack_top, (av == kv) ? 1 : 0);
            end
        end

        // R5 R4: local store pops, local load pushes
        start_prog();
        emit(F_LDC, 77); emit(F_LDC, 5); emit(F_STL, 3); emit(F_LDL, 3); emit(F_OPR, 5);
        run_prog();
        check("R5 local load/store", stack_top, 82);
        check("R5 stored word", dmem[WS/4 + 3], 5);

        // R6: pointers and non-local access
        start_prog();
        emit(F_LDLP, 5);
        run_prog();
        check("R6 local pointer", stack_top, WS + 20);
        start_prog();
        emit(F_LDC, 100); emit(F_LDNLP, 3);
        run_prog();
        check("R6 non-local pointer", stack_top, 112);
        start_prog();
        emit(F_LDC, 99); emit(F_LDLP, 8); emit(F_STNL, 2); emit(F_LDLP, 8); emit(F_LDNL, 2);
        run_prog();
        check("R6 non-local load", stack_top, 99);
        check("R6 non-local store", dmem[(WS + 40)/4], 99);

        // R10: adjust workspace
        start_prog();
        emit(F_AJW, 4); emit(F_AJW, -1); emit(F_LDLP, 0);
        run_prog();
        check("R10 adjust workspace", stack_top, WS + 12);

        // R7: jump distance sweep
        for (int d = 0; d <= 20; d++) begin
            start_prog();
            emit(F_LDC, 1);
            emit(F_J, d);
            for (int k = 0; k < d; k++) raw(8'h49);
            emit(F_ADC, 5);
            run_prog();
            check("R7 jump skip", stack_top, 6);
        end

        // R8: conditional jump taken and not taken
        start_prog();
        emit(F_LDC, 4); emit(F_LDC, 0); emit(F_CJ, 1); emit(F_ADC, 2); emit(F_ADC, 1);
        run_prog();
        check("R8 taken keeps stack", stack_top, 1);
        start_prog();
        emit(F_LDC, 4); emit(F_LDC, 6); emit(F_CJ, 1); emit(F_ADC, 2); emit(F_ADC, 1);
        run_prog();
        check("R8 not taken pops", stack_top, 7);

        // R12: sequential fetch from reset address
        start_prog();
        emit(F_LDC, 1); emit(F_ADC, 1); emit(F_ADC, 1); emit(F_ADC, 1);
        run_prog();
        check("R12 straight-line result", stack_top, 4);
        ok = (flog[0] == 0 && flog[1] == 1 && flog[2] == 2 && flog[3] == 3) ? 1 : 0;
        check("R12 fetch order", ok, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule